// File: doc/BRIEF.md
# UART Interrupt Source Identifier

This block sits next to a UART that has receive and transmit FIFOs. It watches the UART's status events and keeps one pending flag for each of four interrupt sources. Those sources are receive line errors, received-data availability (or the receive FIFO reaching its trigger level), a receive character timeout, and transmit space becoming available. Each flag is cleared by the register access strobe that belongs to that source. A fixed priority picks one enabled pending source, and the block presents it as a 3-bit identification code. An interrupt request output and a 2-bit FIFO-mode field accompany the code.

The character-timeout source uses a small counter. The counter advances on a character-time tick and restarts whenever the receive FIFO takes in or gives out a character. When four idle character times pass while the FIFO holds data, the timeout source becomes pending. The serial logic, baud timing, FIFO storage and bus decode are outside the block. They reach it only as strobes and flags.

Top module: `uart_irq_ident`

## Requirements
- R1: During and right after reset, the code is 000, the FIFO-mode field is 00, the request is low and no source is pending.
- R2: A line error pulse makes code 011 visible one clock later. This is the highest priority. The source stays pending until a line-status read strobe arrives.
- R3: In non-FIFO mode, a rising edge on the receive-available flag raises the received-data source (code 010). A receive-buffer read clears it, and so does the flag going low.
- R4: In FIFO mode, the received-data source (code 010) is raised when the receive count rises to or above the trigger level. It is cleared by a receive-buffer read, or in any cycle where the count is below the trigger.
- R5: In FIFO mode, with a nonzero receive count, the fourth character-time tick without a push or pop raises the timeout source (code 110) one clock later. A receive-buffer read clears it.
- R6: The timeout counter restarts on every receive push or pop. It stays at zero while the receive count is zero or the block is in non-FIFO mode.
- R7: A rising edge on the transmit-ready flag raises the transmit source (code 001). A transmit write strobe clears it.
- R8: An identification read clears the transmit source only when the code shown during that read is 001. Otherwise the transmit source stays pending.
- R9: The priority order is line error, then received data, then timeout, then transmit. Lower sources stay pending while a higher one is shown.
- R10: Enable bits mask the sources: bit0 line error, bit1 received data, bit2 timeout, bit3 transmit. A masked source never appears in the code. The request output is high exactly when the code is nonzero.
- R11: The FIFO-mode field reads 11 one clock after FIFO mode is selected and 00 one clock after non-FIFO mode is selected. The values 01 and 10 are never produced.
- R12: If a source's set condition and its clear strobe occur in the same cycle, the source ends up pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fifo_mode_i | input | 1 | 1 selects FIFO mode |
| line_err_i | input | 1 | Pulse for an overrun, parity, framing or break event |
| rx_avail_i | input | 1 | Receive byte present (non-FIFO mode) |
| rx_count_i | input | CNT_W | Receive FIFO occupancy |
| rx_trig_i | input | CNT_W | Receive FIFO trigger level |
| rx_push_i | input | 1 | Character written into the receive FIFO |
| rx_pop_i | input | 1 | Character taken from the receive FIFO |
| char_tick_i | input | 1 | One pulse per character time |
| tx_ready_i | input | 1 | Transmit holding register or FIFO empty |
| lsr_rd_i | input | 1 | Line-status read strobe |
| rbr_rd_i | input | 1 | Receive-buffer read strobe |
| iir_rd_i | input | 1 | Identification read strobe |
| thr_wr_i | input | 1 | Transmit write strobe |
| en_i | input | 4 | Per-source enable mask |
| irq_id_o | output | 3 | Identification code of the winning source |
| fifo_mode_o | output | 2 | FIFO-mode field |
| irq_o | output | 1 | Interrupt request |

## Verification
A set condition or clear strobe applied before a rising edge shows up in the code right after that edge. This is because each pending flag is a single register, and the code is derived from the flags and the enables without further registers. A change to the enables therefore affects the code in the same cycle, with no clock needed. The FIFO-mode field lags its input by one edge. The bench drives every input on the falling edge. It then waits for one rising edge and samples on the next falling edge, so each expectation lines up with the single register stage on its path. The timeout checks count ticks so that the code is expected to stay 000 after the third tick and to become 110 only after the fourth.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;
  localparam int NSRC     = 4;
  localparam int SRC_LINE = 0;
  localparam int SRC_RXD  = 1;
  localparam int SRC_TMO  = 2;
  localparam int SRC_TXE  = 3;

  typedef enum logic [2:0] {
    ID_NONE = 3'b000,
    ID_TXE  = 3'b001,
    ID_RXD  = 3'b010,
    ID_LINE = 3'b011,
    ID_TMO  = 3'b110
  } irq_id_e;
endpackage

// File: rtl/uart_irq_timeout.sv
module uart_irq_timeout #(
  parameter int CNT_W    = 5,
  parameter int TO_CHARS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_mode_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic             char_tick_i,
  output logic             tmo_set_o
);
  localparam int TO_W = $clog2(TO_CHARS + 1);
  localparam logic [TO_W-1:0] TO_MAX  = TO_W'(TO_CHARS);
  localparam logic [TO_W-1:0] TO_LAST = TO_W'(TO_CHARS - 1);

  logic [TO_W-1:0] cnt_q;
  logic            idle_hold;
  logic            activity;

  assign activity  = rx_push_i | rx_pop_i;
  assign idle_hold = ~fifo_mode_i | (rx_count_i == '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (idle_hold || activity) cnt_q <= '0;
    else if (char_tick_i && cnt_q != TO_MAX) cnt_q <= cnt_q + 1'b1;
  end

  // fires once, on the tick that completes the idle window
  assign tmo_set_o = ~idle_hold & ~activity & char_tick_i & (cnt_q == TO_LAST);

  assert_tmo_restart_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_push_i || rx_pop_i) |=> (cnt_q == '0));
  assert_tmo_empty_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rx_count_i == '0) |=> (cnt_q == '0));
  assert_tmo_no_fire_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!fifo_mode_i || rx_count_i == '0) |-> !tmo_set_o);
endmodule

// File: rtl/uart_irq_flags.sv
module uart_irq_flags
  import uart_irq_pkg::*;
#(
  parameter int CNT_W = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_mode_i,
  input  logic             line_err_i,
  input  logic             rx_avail_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             tx_ready_i,
  input  logic             tmo_set_i,
  input  logic             lsr_rd_i,
  input  logic             rbr_rd_i,
  input  logic             thr_wr_i,
  input  logic             tx_ack_i,
  output logic [NSRC-1:0]  pend_o
);
  logic            rx_cond, rx_cond_q, tx_rdy_q;
  logic [NSRC-1:0] set, clr, pend_q;

  assign rx_cond = fifo_mode_i ? (rx_count_i >= rx_trig_i) : rx_avail_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rx_cond_q <= 1'b0;
      tx_rdy_q  <= 1'b0;
    end else begin
      rx_cond_q <= rx_cond;
      tx_rdy_q  <= tx_ready_i;
    end
  end

  always_comb begin
    set[SRC_LINE] = line_err_i;
    clr[SRC_LINE] = lsr_rd_i;
    set[SRC_RXD]  = rx_cond & ~rx_cond_q;
    clr[SRC_RXD]  = rbr_rd_i | ~rx_cond;
    set[SRC_TMO]  = tmo_set_i;
    clr[SRC_TMO]  = rbr_rd_i;
    set[SRC_TXE]  = tx_ready_i & ~tx_rdy_q;
    clr[SRC_TXE]  = thr_wr_i | tx_ack_i;
  end

  for (genvar i = 0; i < NSRC; i++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) pend_q[i] <= 1'b0;
      else         pend_q[i] <= set[i] | (pend_q[i] & ~clr[i]);
    end

    assert_set_wins_R12: assert property (@(posedge clk_i) disable iff (!rst_ni)
      set[i] |=> pend_q[i]);
    assert_clear_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr[i] && !set[i]) |=> !pend_q[i]);
  end

  assert_rx_below_trig_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fifo_mode_i && rx_count_i < rx_trig_i) |=> !pend_q[SRC_RXD]);
  assert_line_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q[SRC_LINE] && !lsr_rd_i) |=> pend_q[SRC_LINE]);

  assign pend_o = pend_q;
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NSRC-1:0] pend_i,
  input  logic [NSRC-1:0] en_i,
  output irq_id_e         id_o
);
  logic [NSRC-1:0] act;
  assign act = pend_i & en_i;

  always_comb begin
    if (act[SRC_LINE])     id_o = ID_LINE;
    else if (act[SRC_RXD]) id_o = ID_RXD;
    else if (act[SRC_TMO]) id_o = ID_TMO;
    else if (act[SRC_TXE]) id_o = ID_TXE;
    else                   id_o = ID_NONE;
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int TO_CHARS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fifo_mode_i,
  input  logic             line_err_i,
  input  logic             rx_avail_i,
  input  logic [CNT_W-1:0] rx_count_i,
  input  logic [CNT_W-1:0] rx_trig_i,
  input  logic             rx_push_i,
  input  logic             rx_pop_i,
  input  logic             char_tick_i,
  input  logic             tx_ready_i,
  input  logic             lsr_rd_i,
  input  logic             rbr_rd_i,
  input  logic             iir_rd_i,
  input  logic             thr_wr_i,
  input  logic [3:0]       en_i,
  output logic [2:0]       irq_id_o,
  output logic [1:0]       fifo_mode_o,
  output logic             irq_o
);
  logic            tmo_set, tx_ack, fm_q;
  logic [NSRC-1:0] pend;
  irq_id_e         id;

  uart_irq_timeout #(.CNT_W(CNT_W), .TO_CHARS(TO_CHARS)) u_tmo (
    .clk_i, .rst_ni, .fifo_mode_i, .rx_count_i, .rx_push_i, .rx_pop_i,
    .char_tick_i, .tmo_set_o(tmo_set)
  );

  // transmit source is acknowledged only by a read that shows it
  assign tx_ack = iir_rd_i & (id == ID_TXE);

  uart_irq_flags #(.CNT_W(CNT_W)) u_flags (
    .clk_i, .rst_ni, .fifo_mode_i, .line_err_i, .rx_avail_i, .rx_count_i,
    .rx_trig_i, .tx_ready_i, .tmo_set_i(tmo_set), .lsr_rd_i, .rbr_rd_i,
    .thr_wr_i, .tx_ack_i(tx_ack), .pend_o(pend)
  );

  uart_irq_prio u_prio (.pend_i(pend), .en_i(en_i), .id_o(id));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) fm_q <= 1'b0;
    else         fm_q <= fifo_mode_i;
  end

  assign irq_id_o    = id;
  assign fifo_mode_o = {2{fm_q}};
  assign irq_o       = (id != ID_NONE);

  assert_line_top_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend[SRC_LINE] && en_i[SRC_LINE]) |-> (irq_id_o == 3'b011));
  assert_mask_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i == 4'b0000) |-> !irq_o);
  assert_tx_kept_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (iir_rd_i && irq_id_o != 3'b001 && pend[SRC_TXE] && !thr_wr_i) |=> pend[SRC_TXE]);
  assert_fifo_field_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (fifo_mode_o == {2{$past(fifo_mode_i)}}));
endmodule

// File: tb/tb_uart_irq_ident.sv
module tb_uart_irq_ident;
  localparam int CNT_W = 5;
  localparam int NV    = 25;
  localparam int VW    = 25;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic fifo_mode_i = 0, line_err_i = 0, rx_avail_i = 0, rx_push_i = 0, rx_pop_i = 0;
  logic char_tick_i = 0, tx_ready_i = 0, lsr_rd_i = 0, rbr_rd_i = 0, iir_rd_i = 0, thr_wr_i = 0;
  logic [CNT_W-1:0] rx_count_i = '0, rx_trig_i = 5'd1;
  logic [3:0] en_i = 4'hF;
  logic [2:0] irq_id_o;
  logic [1:0] fifo_mode_o;
  logic irq_o;

  int total = 0, fails = 0;

  always #5 clk = ~clk;

  uart_irq_ident #(.CNT_W(CNT_W), .TO_CHARS(4)) dut (
    .clk_i(clk), .rst_ni, .fifo_mode_i, .line_err_i, .rx_avail_i, .rx_count_i,
    .rx_trig_i, .rx_push_i, .rx_pop_i, .char_tick_i, .tx_ready_i, .lsr_rd_i,
    .rbr_rd_i, .iir_rd_i, .thr_wr_i, .en_i, .irq_id_o, .fifo_mode_o, .irq_o
  );

  // {fm, le, ra, tr, lsr, rbr, iir, thr, en[3:0], cnt, trig, exp_id}
  localparam logic [VW-1:0] VEC [NV] = '{
    {8'b0000_0000, 4'hF, 5'd0, 5'd1, 3'b000},  // 0  R1 idle
    {8'b0010_0000, 4'hF, 5'd0, 5'd1, 3'b010},  // 1  R3 byte avail
    {8'b0011_0000, 4'hF, 5'd0, 5'd1, 3'b010},  // 2  R9 tx below rxd
    {8'b0111_0000, 4'hF, 5'd0, 5'd1, 3'b011},  // 3  R2 line error on top
    {8'b0011_0000, 4'hF, 5'd0, 5'd1, 3'b011},  // 4  R2 stays pending
    {8'b0011_1000, 4'hF, 5'd0, 5'd1, 3'b010},  // 5  R2 lsr read clears
    {8'b0011_0100, 4'hF, 5'd0, 5'd1, 3'b001},  // 6  R3 rbr read clears
    {8'b0011_0010, 4'hF, 5'd0, 5'd1, 3'b000},  // 7  R8 iir read shows 001
    {8'b0000_0000, 4'hF, 5'd0, 5'd1, 3'b000},  // 8  R7 ready falls
    {8'b0001_0000, 4'hF, 5'd0, 5'd1, 3'b001},  // 9  R7 ready rises
    {8'b0101_0000, 4'hF, 5'd0, 5'd1, 3'b011},  // 10 R9
    {8'b0001_0010, 4'hF, 5'd0, 5'd1, 3'b011},  // 11 R8 iir read while 011
    {8'b0001_1000, 4'hF, 5'd0, 5'd1, 3'b001},  // 12 R8 tx survived
    {8'b0001_0001, 4'hF, 5'd0, 5'd1, 3'b000},  // 13 R7 thr write clears
    {8'b1000_0000, 4'hF, 5'd3, 5'd4, 3'b000},  // 14 R4 below trigger
    {8'b1000_0000, 4'hF, 5'd4, 5'd4, 3'b010},  // 15 R4 at trigger
    {8'b1000_0000, 4'hF, 5'd3, 5'd4, 3'b000},  // 16 R4 drop clears
    {8'b1000_0000, 4'hF, 5'd5, 5'd4, 3'b010},  // 17 R4 above trigger
    {8'b1000_0000, 4'hD, 5'd5, 5'd4, 3'b000},  // 18 R10 rxd masked
    {8'b1000_0100, 4'hF, 5'd5, 5'd4, 3'b000},  // 19 R4 rbr clears
    {8'b1100_0000, 4'hE, 5'd5, 5'd4, 3'b000},  // 20 R10 line masked
    {8'b1000_0000, 4'hF, 5'd5, 5'd4, 3'b011},  // 21 R10 unmask shows it
    {8'b1000_1000, 4'hF, 5'd5, 5'd4, 3'b000},  // 22 R2
    {8'b1100_1000, 4'hF, 5'd5, 5'd4, 3'b011},  // 23 R12 set beats clear
    {8'b1000_1000, 4'hF, 5'd5, 5'd4, 3'b000}   // 24 R2
  };

  function automatic string vtag(int i);
    case (i)
      0: return "R1";  1, 6: return "R3";  2, 10: return "R9";
      3, 4, 5, 22, 24: return "R2";  7, 11, 12: return "R8";
      8, 9, 13: return "R7";  14, 15, 16, 17, 19: return "R4";
      18, 20, 21: return "R10";  default: return "R12";
    endcase
  endfunction

  task automatic step();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input logic [2:0] eid, input logic [1:0] efm, input string tag);
    total++;
    if (irq_id_o !== eid || irq_o !== (eid != 3'b000) || fifo_mode_o !== efm) begin
      fails++;
      $display("FAIL %s: id=%b irq=%b fm=%b expected id=%b irq=%b fm=%b",
               tag, irq_id_o, irq_o, fifo_mode_o, eid, (eid != 3'b000), efm);
    end
  endtask

  task automatic pulse_tick(); char_tick_i = 1; step(); char_tick_i = 0; endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog: run hung, actual=timeout expected=done");
    finish_run();
  end

  initial begin
    fifo_mode_i = 1;  // reset must still show 00 in the field
    repeat (3) @(negedge clk);
    check(3'b000, 2'b00, "R1 in reset");
    fifo_mode_i = 0;
    rst_ni = 1;
    step();
    check(3'b000, 2'b00, "R1 after reset");

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      {fifo_mode_i, line_err_i, rx_avail_i, tx_ready_i,
       lsr_rd_i, rbr_rd_i, iir_rd_i, thr_wr_i} = v[24:17];
      en_i = v[16:13]; rx_count_i = v[12:8]; rx_trig_i = v[7:3];
      step();
      check(v[2:0], {2{v[24]}}, vtag(i));
    end
    {line_err_i, lsr_rd_i} = 2'b00;

    // R11 field returns to 00
    fifo_mode_i = 0; rx_count_i = 0; step();
    check(3'b000, 2'b00, "R11 back to non-fifo");

    // R12 on transmit: edge and write together
    tx_ready_i = 1; thr_wr_i = 1; step();
    thr_wr_i = 0;
    check(3'b001, 2'b00, "R12 tx set beats thr write");
    thr_wr_i = 1; step(); thr_wr_i = 0;
    check(3'b000, 2'b00, "R7 thr write clears");
    tx_ready_i = 0;

    // R5 timeout after four idle ticks
    fifo_mode_i = 1; rx_trig_i = 5'd8; rx_count_i = 5'd2;
    rx_push_i = 1; step(); rx_push_i = 0;
    for (int k = 0; k < 3; k++) pulse_tick();
    check(3'b000, 2'b11, "R5 three ticks not enough");
    pulse_tick();
    check(3'b110, 2'b11, "R5 fourth tick fires");
    // R9 received data beats timeout, timeout stays pending
    rx_count_i = 5'd8; step();
    check(3'b010, 2'b11, "R9 rxd over timeout");
    rx_count_i = 5'd2; step();
    check(3'b110, 2'b11, "R9 timeout still pending");
    rbr_rd_i = 1; step(); rbr_rd_i = 0;
    check(3'b000, 2'b11, "R5 rbr read clears");

    // R6 push restarts the window
    rx_push_i = 1; step(); rx_push_i = 0;
    for (int k = 0; k < 3; k++) pulse_tick();
    rx_pop_i = 1; step(); rx_pop_i = 0;
    for (int k = 0; k < 3; k++) pulse_tick();
    check(3'b000, 2'b11, "R6 pop restarted count");
    pulse_tick();
    check(3'b110, 2'b11, "R6 fires after restart");
    rbr_rd_i = 1; step(); rbr_rd_i = 0;

    // R6 empty FIFO holds counter at zero
    rx_count_i = 0; rx_pop_i = 1; step(); rx_pop_i = 0;
    for (int k = 0; k < 6; k++) pulse_tick();
    check(3'b000, 2'b11, "R6 empty fifo no timeout");

    // R6 non-FIFO mode holds counter at zero
    fifo_mode_i = 0; rx_count_i = 5'd2; step();
    for (int k = 0; k < 6; k++) pulse_tick();
    check(3'b000, 2'b00, "R6 non-fifo no timeout");

    finish_run();
  end
endmodule